// File: doc/BRIEF.md
# Mirrored Byte-Count Table Writer

This block turns descriptor-enqueue events into writes to an on-chip table memory. Each event names a queue (0 to 15), a ring slot (0 to 255) and a frame byte count. The block writes the byte count into that queue's table. Each queue owns 320 sixteen-bit entries: the 256 ring slots, then 64 copies of slots 0 to 63. Because of these copies, a consumer can read any window of up to 64 consecutive slots as one straight run of addresses, even when the window passes the ring's last slot.

The block counts the pending descriptors on each ring, so that no ring ever holds more than 255 of them. A completion input lowers the count of one queue. An enqueue to a full ring is accepted at the handshake, but the block drops it and raises an overflow pulse. The memory port is halfword addressed. A queue's table starts every 512 halfwords, which is 1024 bytes.

Top module: `bcnt_table_writer`

## Requirements
- R1: An accepted enqueue to a ring that is not full writes one cycle after acceptance, at halfword address queue*512 + slot (byte address queue*1024 + slot*2).
- R2: When the slot is below 64, a second write follows in the very next cycle at the primary address + 256, with the same data. A slot of 64 or more produces exactly one write.
- R3: Each written word holds the byte count in bits [11:0], and bits [15:12] are zero.
- R4: A byte count above 4095 is written as 4095. `size_err` is high in the same cycle as that entry's primary write, and low in every other cycle.
- R5: A ring holds at most 255 pending descriptors. An enqueue accepted while its queue holds 255 produces no write. Instead, `overflow` is high for one cycle, one cycle after acceptance.
- R6: A completion lowers its queue's count by one when that count is nonzero. A completion on an empty queue is ignored. A completion in the same cycle as an enqueue to a full queue of the same number does not make room for that enqueue.
- R7: `enq_ready` is low for the one cycle that follows the acceptance of an enqueue whose slot is below 64, and high in every other cycle.
- R8: After reset, no write is issued, `enq_ready` is high, both flags are low and every queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue event present |
| enq_ready | output | 1 | Block can accept an event this cycle |
| enq_queue | input | 4 | Queue number |
| enq_slot | input | 8 | Ring slot index |
| enq_bytes | input | 16 | Frame byte count |
| done_valid | input | 1 | One descriptor completed |
| done_queue | input | 4 | Queue of the completed descriptor |
| mem_we | output | 1 | Table write enable |
| mem_addr | output | 13 | Table halfword address |
| mem_wdata | output | 16 | Table write data |
| overflow | output | 1 | Pulse: enqueue dropped because its ring was full |
| size_err | output | 1 | Pulse: byte count saturated at 4095 |

## Verification
The bench fills one ring to exactly 255 entries and enqueues once more. A cap that is off by one would write that entry, or would refuse the entry before it. It then issues a completion in the same cycle as a further enqueue, then an enqueue after the completion has taken effect, and a completion on an empty queue, which must not wrap the count around. It checks slots 63 and 64, where a wrong mirror boundary would write a stray copy or leave a copy out. It also sends the byte counts 4095, 4096 and 65535, where a truncating design would write 0 instead of 4095. Random traffic, mixed with completions, then checks every address, data word and ready gap against a reference model.

// File: rtl/bcnt_table_writer.sv
module bcnt_table_writer #(
  parameter int NUM_Q      = 16,
  parameter int SLOTS      = 256,
  parameter int MIRROR     = 64,
  parameter int STRIDE_B   = 1024,
  parameter int CNT_W      = 12,
  parameter int IN_W       = 16,
  parameter int MAX_PEND   = 255,
  parameter int QW         = $clog2(NUM_Q),
  parameter int SW         = $clog2(SLOTS),
  parameter int AW         = $clog2(NUM_Q * STRIDE_B / 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enq_valid,
  output logic            enq_ready,
  input  logic [QW-1:0]   enq_queue,
  input  logic [SW-1:0]   enq_slot,
  input  logic [IN_W-1:0] enq_bytes,
  input  logic            done_valid,
  input  logic [QW-1:0]   done_queue,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [15:0]     mem_wdata,
  output logic            overflow,
  output logic            size_err
);
  localparam int HW_PER_Q = STRIDE_B / 2;
  localparam int OCC_W    = $clog2(MAX_PEND + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [OCC_W-1:0] occ [NUM_Q];
  logic             mir_pend;
  logic             fire, full, big;
  logic [AW-1:0]    prim_addr;
  logic [CNT_W-1:0] cnt;

  assign enq_ready = !mir_pend;
  assign fire      = enq_valid && enq_ready;
  assign full      = occ[enq_queue] == OCC_W'(MAX_PEND);
  assign big       = enq_bytes > IN_W'(CNT_MAX);
  assign cnt       = big ? CNT_MAX : enq_bytes[CNT_W-1:0];
  assign prim_addr = AW'(enq_queue) * AW'(HW_PER_Q) + AW'(enq_slot);

  for (genvar i = 0; i < NUM_Q; i++) begin : g_occ
    logic inc, dec;
    assign inc = fire && !full && enq_queue == QW'(i);
    assign dec = done_valid && done_queue == QW'(i) && occ[i] != '0;
    always_ff @(posedge clk) begin
      if (!rst_n) occ[i] <= '0;
      else if (inc && !dec) occ[i] <= occ[i] + 1'b1;
      else if (dec && !inc) occ[i] <= occ[i] - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mir_pend  <= 1'b0;
      overflow  <= 1'b0;
      size_err  <= 1'b0;
    end else begin
      overflow <= fire && full;
      size_err <= fire && !full && big;
      if (fire && !full) begin
        mem_we    <= 1'b1;
        mem_addr  <= prim_addr;
        mem_wdata <= 16'(cnt);
        mir_pend  <= enq_slot < SW'(MIRROR);
      end else if (mir_pend) begin
        mem_we    <= 1'b1;
        mem_addr  <= mem_addr + AW'(SLOTS);
        mir_pend  <= 1'b0;
      end else begin
        mem_we    <= 1'b0;
      end
    end
  end

  a_r2_mirror_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mir_pend) |=> (mem_we && mem_addr == $past(mem_addr) + AW'(SLOTS)
                              && mem_wdata == $past(mem_wdata)));
  a_r7_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !full && enq_slot < SW'(MIRROR)) |=> !enq_ready);
  a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && full) |=> (overflow && !mem_we));
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[15:CNT_W] == '0);
  a_r4_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> (mem_we && mem_wdata == 16'(CNT_MAX)));
  a_r5_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && size_err));
endmodule

// File: tb/bcnt_table_writer_test.sv
`timescale 1ns/1ps
module bcnt_table_writer_test;
  logic clk = 0, rst_n = 0;
  logic enq_valid = 0, done_valid = 0;
  logic [3:0] enq_queue = 0, done_queue = 0;
  logic [7:0] enq_slot = 0;
  logic [15:0] enq_bytes = 0;
  logic enq_ready, mem_we, overflow, size_err;
  logic [12:0] mem_addr;
  logic [15:0] mem_wdata;

  always #2 clk = ~clk;

  bcnt_table_writer uut (.*);

  int checks = 0, errors = 0;
  int occ [16];
  int eaddr[$], edata[$], eerr[$];
  string etag[$];
  int exp_ovf = 0;
  bit have_last = 0, last_mir = 0;
  bit done_flag = 0;

  function automatic int f_addr(int q, int s); return q * 512 + s; endfunction
  function automatic int f_data(int b); return (b > 4095) ? 4095 : b; endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares every write and every flag with the model
  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      if (eaddr.size() == 0) chk(0, "R5/R2 unexpected write", mem_addr, -1);
      else begin
        int a, d, e; string t;
        a = eaddr.pop_front(); d = edata.pop_front(); e = eerr.pop_front(); t = etag.pop_front();
        chk(mem_addr == a, {t, " addr"}, mem_addr, a);
        chk(mem_wdata == d, {t, " data R3"}, mem_wdata, d);
        chk(size_err == e, {t, " size_err R4"}, size_err, e);
      end
    end else if (size_err) chk(0, "R4 size_err without write", 1, 0);
    if (overflow) begin
      chk(exp_ovf > 0, "R5 overflow pulse", 1, exp_ovf);
      if (exp_ovf > 0) exp_ovf--;
    end
  end

  task automatic step(bit ev, int q, int s, int b, bit dv, int dq, string tag);
    bit full, acc;
    @(negedge clk);
    enq_valid = 0; done_valid = 0;
    if (have_last) begin
      chk(enq_ready == !last_mir, "R7 ready after accept", enq_ready, !last_mir);
      have_last = 0;
    end
    while (!enq_ready) @(negedge clk);
    enq_valid = ev; enq_queue = q[3:0]; enq_slot = s[7:0]; enq_bytes = b[15:0];
    done_valid = dv; done_queue = dq[3:0];
    full = occ[q] == 255;
    acc = ev && !full;
    if (ev && full) exp_ovf++;
    if (acc) begin
      eaddr.push_back(f_addr(q, s)); edata.push_back(f_data(b));
      eerr.push_back(b > 4095); etag.push_back({tag, " R1"});
      if (s < 64) begin
        eaddr.push_back(f_addr(q, s) + 256); edata.push_back(f_data(b));
        eerr.push_back(0); etag.push_back({tag, " R2 mirror"});
      end
      have_last = 1; last_mir = s < 64;
    end
    if (dv && occ[dq] > 0) occ[dq]--;
    if (acc) occ[q]++;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); enq_valid = 0; done_valid = 0;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4965));
    foreach (occ[i]) occ[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_we == 0, "R8 no write in reset", mem_we, 0);
    rst_n = 1;
    @(negedge clk);
    chk(enq_ready == 1, "R8 ready after reset", enq_ready, 1);
    chk(overflow == 0 && size_err == 0, "R8 flags low", overflow | size_err, 0);
    // directed slot and count edges
    step(1, 0, 0, 100, 0, 0, "dir slot0");
    step(1, 15, 255, 1500, 0, 0, "dir q15 s255");
    step(1, 2, 63, 4095, 0, 0, "dir slot63 4095");
    step(1, 2, 64, 4096, 0, 0, "dir slot64 R4 4096");
    step(1, 7, 10, 65535, 0, 0, "dir R4 65535");
    // R6 completion on empty queue must not wrap
    step(0, 0, 0, 0, 1, 9, "R6 empty");
    step(1, 9, 200, 1, 0, 0, "R6 after empty completion");
    // fill queue 3 to the R5 cap
    for (int i = 0; i < 255; i++) step(1, 3, 64 + (i % 192), i, 0, 0, "fill");
    step(1, 3, 70, 55, 0, 0, "R5 full drop");
    step(1, 3, 71, 56, 1, 3, "R6 same cycle no room");
    step(1, 3, 72, 57, 0, 0, "R6 freed slot");
    step(1, 3, 73, 58, 0, 0, "R5 full again");
    idle(3);
    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int q, s, b;
      q = $urandom_range(0, 3);
      s = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 63) : $urandom_range(0, 255);
      b = ($urandom_range(0, 7) == 0) ? $urandom_range(4090, 65535) : $urandom_range(0, 4100);
      step($urandom_range(0, 4) != 0, q, s, b, $urandom_range(0, 2) == 0,
           $urandom_range(0, 3), "rand");
    end
    idle(5);
    chk(eaddr.size() == 0, "R2 all writes seen", eaddr.size(), 0);
    chk(exp_ovf == 0, "R5 all overflows seen", exp_ovf, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule